// File: doc/BRIEF.md
# CORDIC Result Recovery and Single-Precision Packer

This block is the last stage behind a reconfigurable CORDIC core. The core reports three fixed-point paths (X, Y, Z) as 25-bit two's-complement numbers with one sign bit, one integer bit and 23 fraction bits. The block also receives the operation class and the angle sector that the front end chose when it folded a trigonometric input into the core's convergence range, plus an exponent that the front end already worked out for multiply and divide.

For trigonometric work the block first undoes that folding. Depending on the sector it swaps and negates X and Y and adds or subtracts a quarter or half turn on Z. Every other operation class passes the three paths through untouched. Each recovered path then goes through its own leading-one normaliser, which turns it into an IEEE-754 single-precision word with a truncated mantissa. The three floats leave the block together with a valid strobe, two clock cycles after the inputs were sampled.

Top module: `cordic_post_pack`

## Requirements
- R1: When `op_class` is not 00 (trigonometric), the region code has no effect and X, Y and Z are each converted exactly as they arrive.
- R2: With `op_class` = 00 and `region` = 0, or any reserved region value 5 to 7, X, Y and Z are converted unchanged.
- R3: With `op_class` = 00 and `region` = 1, the X output is the conversion of −Y, the Y output that of X, and Z is converted after adding π/2. π/2 is taken as round(π/2·2^23) in the 23-fraction-bit scale.
- R4: With `op_class` = 00 and `region` = 2 or 3, X and Y are both negated before conversion. Z gains +π for region 2 and −π for region 3, with π taken as round(π·2^23).
- R5: With `op_class` = 00 and `region` = 4, the X output is the conversion of Y, the Y output that of −X, and Z is converted after subtracting π/2.
- R6: A nonzero path value v, scaled by 2^-23, whose magnitude has its highest set bit at position p is packed as follows: bit 31 is the sign, bits 30:23 hold 127 + p − 23, and bits 22:0 hold the 23 magnitude bits directly below the leading one. Missing bits are zero-filled and extra bits are truncated. For example 1.0 gives 0x3F800000 and 2^-23 gives 0x34000000.
- R7: A zero path value packs to 0x00000000 (+0.0), whatever operation or region produced it.
- R8: Negative values are packed by sign and magnitude: −1.0 gives 0xBF800000.
- R9: For `op_class` = 01 (multiply) the Y path uses `exp_pre` + p − 23 as its exponent field. For `op_class` = 10 (divide) the Z path does the same. All other paths use the positional exponent of R6.
- R10: `out_valid` rises exactly two rising edges after `in_valid` is sampled high, together with its three floats. It stays low otherwise, also for back-to-back inputs. During reset `out_valid` and all three floats are zero.

Class encoding: 00 trigonometric, 01 multiply, 10 divide, 11 other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs on this cycle are a result to convert |
| x_fix | input | 25 | X path, two's complement, 23 fraction bits |
| y_fix | input | 25 | Y path, two's complement, 23 fraction bits |
| z_fix | input | 25 | Z path, two's complement, 23 fraction bits |
| region | input | 3 | Sector code chosen by range reduction (0 to 4) |
| op_class | input | 2 | 00 trig, 01 multiply, 10 divide, 11 other |
| exp_pre | input | 8 | Precomputed biased exponent for multiply/divide |
| out_valid | output | 1 | Floats on this cycle are valid |
| x_flt | output | 32 | X result, single precision |
| y_flt | output | 32 | Y result, single precision |
| z_flt | output | 32 | Z result, single precision |

## Verification
Each result is due on the second rising edge after its inputs are sampled. One edge is taken by sector recovery and one by packing. The bench drives inputs on a falling edge and reads all three floats and `out_valid` two falling edges later, midway between the edges, for every scenario. A streaming test feeds four results on consecutive cycles. At each falling edge it checks the result launched two cycles before, and it then checks that `out_valid` drops once the stream ends.

// File: rtl/cpp_pkg.sv
// Shared encodings and float field widths for the CORDIC result packer.
// Assumes single-precision output with a standard bias.
package cpp_pkg;

    typedef enum logic [1:0] {
        OP_TRIG  = 2'b00,
        OP_MUL   = 2'b01,
        OP_DIV   = 2'b10,
        OP_OTHER = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        SEC_RIGHT    = 3'd0,
        SEC_TOP      = 3'd1,
        SEC_LEFT_POS = 3'd2,
        SEC_LEFT_NEG = 3'd3,
        SEC_BOTTOM   = 3'd4
    } sector_e;

    localparam int FLT_W  = 32;
    localparam int EXP_W  = 8;
    localparam int MANT_W = 23;
    localparam int BIAS   = 127;

endpackage

// File: rtl/cpp_lead_one.sv
// Leading-one locator: reports the index of the highest set bit of vec.
// Assumes nothing about vec; found is low when vec is all zero.
module cpp_lead_one #(
    parameter int W  = 26,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          found
);

    // Scan upward so the highest set bit wins.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = PW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpp_quadrant_undo.sv
// Sector recovery stage: undoes trigonometric range reduction and registers
// the widened X/Y/Z values with the class, exponent and valid flag.
// Assumes inputs carry FRAC_W fraction bits; REC_W leaves room for +/-pi.
module cpp_quadrant_undo
    import cpp_pkg::*;
#(
    parameter int FIX_W  = 25,
    parameter int FRAC_W = 23,
    parameter int REC_W  = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [FIX_W-1:0]        x_in,
    input  logic [FIX_W-1:0]        y_in,
    input  logic [FIX_W-1:0]        z_in,
    input  logic [2:0]              region,
    input  logic [1:0]              op_class,
    input  logic [EXP_W-1:0]        exp_pre,
    output logic                    s_valid,
    output logic signed [REC_W-1:0] x_r,
    output logic signed [REC_W-1:0] y_r,
    output logic signed [REC_W-1:0] z_r,
    output logic [1:0]              s_class,
    output logic [EXP_W-1:0]        s_exp
);

    localparam int EXT_W     = REC_W - FIX_W;
    localparam int PI_Q      = $rtoi(3.141592653589793 * (2.0 ** FRAC_W) + 0.5);
    localparam int HALF_PI_Q = $rtoi(1.5707963267948966 * (2.0 ** FRAC_W) + 0.5);
    localparam logic signed [REC_W-1:0] PI_V      = REC_W'(PI_Q);
    localparam logic signed [REC_W-1:0] HALF_PI_V = REC_W'(HALF_PI_Q);

    logic signed [REC_W-1:0] x_ext, y_ext, z_ext;
    logic signed [REC_W-1:0] x_nx, y_nx, z_nx;

    assign x_ext = {{EXT_W{x_in[FIX_W-1]}}, x_in};
    assign y_ext = {{EXT_W{y_in[FIX_W-1]}}, y_in};
    assign z_ext = {{EXT_W{z_in[FIX_W-1]}}, z_in};

    // Pick swap, negation and angle offset from the sector code.
    always_comb begin
        x_nx = x_ext;
        y_nx = y_ext;
        z_nx = z_ext;
        if (op_class == OP_TRIG) begin
            case (sector_e'(region))
                SEC_TOP: begin
                    x_nx = -y_ext;
                    y_nx = x_ext;
                    z_nx = z_ext + HALF_PI_V;
                end
                SEC_LEFT_POS: begin
                    x_nx = -x_ext;
                    y_nx = -y_ext;
                    z_nx = z_ext + PI_V;
                end
                SEC_LEFT_NEG: begin
                    x_nx = -x_ext;
                    y_nx = -y_ext;
                    z_nx = z_ext - PI_V;
                end
                SEC_BOTTOM: begin
                    x_nx = y_ext;
                    y_nx = -x_ext;
                    z_nx = z_ext - HALF_PI_V;
                end
                default: ;
            endcase
        end
    end

    // Register the recovered paths and their side information.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            x_r     <= '0;
            y_r     <= '0;
            z_r     <= '0;
            s_class <= '0;
            s_exp   <= '0;
        end else begin
            s_valid <= in_valid;
            x_r     <= x_nx;
            y_r     <= y_nx;
            z_r     <= z_nx;
            s_class <= op_class;
            s_exp   <= exp_pre;
        end
    end

    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class != OP_TRIG) |=>
        (x_r[FIX_W-1:0] == $past(x_in) && z_r[FIX_W-1:0] == $past(z_in)));

    // R4
    negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == OP_TRIG && (region == 3'd2 || region == 3'd3)) |=>
        ((x_r + $past(x_ext)) == '0 && (y_r + $past(y_ext)) == '0));

endmodule

// File: rtl/cpp_float_pack.sv
// Single-path float packer: sign-magnitude split, leading-one search,
// normalising shift and field assembly with a truncated mantissa.
// Assumes the value carries FRAC_W fraction bits and |val| < 2^(REC_W-1).
module cpp_float_pack
    import cpp_pkg::*;
#(
    parameter int REC_W  = 27,
    parameter int FRAC_W = 23
) (
    input  logic signed [REC_W-1:0] val,
    input  logic                    use_pre,
    input  logic [EXP_W-1:0]        exp_pre,
    output logic [FLT_W-1:0]        flt
);

    localparam int MAG_W = REC_W - 1;
    localparam int PW    = $clog2(MAG_W);

    logic             sgn;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] norm;
    logic [PW-1:0]    lead;
    logic             nonzero;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  efield;

    // Split sign and magnitude.
    always_comb begin
        sgn = val[REC_W-1];
        mag = MAG_W'(sgn ? -val : val);
    end

    cpp_lead_one #(.W(MAG_W), .PW(PW)) i_lead (
        .vec   (mag),
        .pos   (lead),
        .found (nonzero)
    );

    // Normalise, pick the exponent source and assemble the word.
    always_comb begin
        norm   = mag << (PW'(MAG_W - 1) - lead);
        mant   = MANT_W'({norm[MAG_W-2:0], {MANT_W{1'b0}}} >> (MAG_W - 1));
        efield = EXP_W'((use_pre ? int'(exp_pre) : BIAS) + int'(lead) - FRAC_W);
        flt    = nonzero ? {sgn, efield, mant} : '0;
    end

    // R6
    always_comb begin
        if (nonzero) begin
            norm_msb_chk: assert (norm[MAG_W-1]);
        end
    end

endmodule

// File: rtl/cordic_post_pack.sv
// CORDIC result recovery and packer: stage one undoes range reduction,
// stage two converts X, Y and Z to single precision and registers them.
// Fixed latency of two cycles; assumes one result per cycle at most.
module cordic_post_pack
    import cpp_pkg::*;
#(
    parameter int FIX_W  = 25,
    parameter int FRAC_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [24:0]      x_fix,
    input  logic [24:0]      y_fix,
    input  logic [24:0]      z_fix,
    input  logic [2:0]       region,
    input  logic [1:0]       op_class,
    input  logic [7:0]       exp_pre,
    output logic             out_valid,
    output logic [31:0]      x_flt,
    output logic [31:0]      y_flt,
    output logic [31:0]      z_flt
);

    localparam int REC_W  = FIX_W + 2;
    localparam int NPATH  = 3;

    logic                    s_valid;
    logic [1:0]              s_class;
    logic [EXP_W-1:0]        s_exp;
    logic signed [REC_W-1:0] rec [NPATH];
    logic [FLT_W-1:0]        packed_w [NPATH];
    logic [FLT_W-1:0]        flt_q [NPATH];

    cpp_quadrant_undo #(.FIX_W(FIX_W), .FRAC_W(FRAC_W), .REC_W(REC_W)) i_undo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .x_in     (x_fix),
        .y_in     (y_fix),
        .z_in     (z_fix),
        .region   (region),
        .op_class (op_class),
        .exp_pre  (exp_pre),
        .s_valid  (s_valid),
        .x_r      (rec[0]),
        .y_r      (rec[1]),
        .z_r      (rec[2]),
        .s_class  (s_class),
        .s_exp    (s_exp)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        logic use_pre;
        // Y takes the multiply exponent, Z the divide exponent.
        assign use_pre = (g == 1 && s_class == OP_MUL) || (g == 2 && s_class == OP_DIV);

        cpp_float_pack #(.REC_W(REC_W), .FRAC_W(FRAC_W)) i_pack (
            .val     (rec[g]),
            .use_pre (use_pre),
            .exp_pre (s_exp),
            .flt     (packed_w[g])
        );

        // Register this path's packed float.
        always_ff @(posedge clk) begin
            if (!rst_n) flt_q[g] <= '0;
            else        flt_q[g] <= packed_w[g];
        end
    end

    // Register the output strobe alongside the data.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s_valid;
    end

    assign x_flt = flt_q[0];
    assign y_flt = flt_q[1];
    assign z_flt = flt_q[2];

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R10
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R7
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && x_flt[30:0] == '0 && y_flt[30:0] == '0) |-> (!x_flt[31] && !y_flt[31]));

endmodule

// File: tb/test_cordic_post_pack.sv
// Directed bench: one task per scenario, expected floats built from the rules.
module test_cordic_post_pack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [24:0] x_fix = '0, y_fix = '0, z_fix = '0;
    logic [2:0]  region = '0;
    logic [1:0]  op_class = '0;
    logic [7:0]  exp_pre = '0;
    logic        out_valid;
    logic [31:0] x_flt, y_flt, z_flt;

    int total = 0;
    int bad = 0;

    localparam longint PI_K   = 26353589;
    localparam longint HPI_K  = 13176795;

    always #2 clk = ~clk;

    cordic_post_pack i_cordic_post_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_fix(x_fix), .y_fix(y_fix), .z_fix(z_fix),
        .region(region), .op_class(op_class), .exp_pre(exp_pre),
        .out_valid(out_valid), .x_flt(x_flt), .y_flt(y_flt), .z_flt(z_flt)
    );

    function automatic logic [31:0] to_flt(longint v, bit use_pre, int ep);
        longint m;
        int p, e;
        logic [22:0] mt;
        if (v == 0) return 32'h0;
        m = (v < 0) ? -v : v;
        p = 0;
        for (int k = 0; k < 40; k++) if ((m >> k) != 0) p = k;
        e = (use_pre ? ep : 127) + p - 23;
        if (p >= 23) mt = 23'((m >> (p - 23)) & 64'h7FFFFF);
        else         mt = 23'((m << (23 - p)) & 64'h7FFFFF);
        return {(v < 0), 8'(e), mt};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic expect_of(int x, int y, int z, int rg, int op, int ep,
                             output logic [31:0] ex, output logic [31:0] ey, output logic [31:0] ez);
        longint xr = x, yr = y, zr = z;
        if (op == 0) begin
            case (rg)
                1: begin xr = -y; yr = x;  zr = z + HPI_K; end
                2: begin xr = -x; yr = -y; zr = z + PI_K;  end
                3: begin xr = -x; yr = -y; zr = z - PI_K;  end
                4: begin xr = y;  yr = -x; zr = z - HPI_K; end
                default: ;
            endcase
        end
        ex = to_flt(xr, 1'b0, 0);
        ey = to_flt(yr, op == 1, ep);
        ez = to_flt(zr, op == 2, ep);
    endtask

    task automatic drive(int x, int y, int z, int rg, int op, int ep, bit v);
        x_fix = 25'(x); y_fix = 25'(y); z_fix = 25'(z);
        region = 3'(rg); op_class = 2'(op); exp_pre = 8'(ep);
        in_valid = v;
    endtask

    task automatic run_one(string tag, int x, int y, int z, int rg, int op, int ep);
        logic [31:0] ex, ey, ez;
        expect_of(x, y, z, rg, op, ep, ex, ey, ez);
        @(negedge clk); drive(x, y, z, rg, op, ep, 1'b1);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 1'b0);
        @(negedge clk);
        check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
        check({tag, " X"}, x_flt, ex);
        check({tag, " Y"}, y_flt, ey);
        check({tag, " Z"}, z_flt, ez);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset valid", {31'b0, out_valid}, 32'd0);
        check("R10 reset X", x_flt, 32'h0);
        check("R10 reset Z", z_flt, 32'h0);
    endtask

    task automatic t_nontrig;
        run_one("R1 other class", 32'h600000, -32'h300000, 32'h123456, 1, 3, 0);
        run_one("R1 mul class region2", 32'h200000, 32'h500000, -32'h0ABCDE, 2, 1, 127);
    endtask

    task automatic t_region0;
        run_one("R2 region0", 32'h5A8279, -32'h5A8279, 32'h0C90FD, 0, 0, 0);
        run_one("R2 reserved region6", 32'h400000, 32'h300000, -32'h111111, 6, 0, 0);
    endtask

    task automatic t_region1;
        run_one("R3 region1", 32'h6ED9EB, 32'h400000, -32'h2345AB, 1, 0, 0);
    endtask

    task automatic t_region23;
        run_one("R4 region2", 32'h3000AA, -32'h7FFFFF, 32'hFFFFFF, 2, 0, 0);
        run_one("R4 region3", -32'h123456, 32'h654321, -32'h400000, 3, 0, 0);
    endtask

    task automatic t_region4;
        run_one("R5 region4", -32'h700000, 32'h0F0F0F, 32'h600000, 4, 0, 0);
    endtask

    task automatic t_format;
        run_one("R6 positional", 32'h800000, 32'h400000, 1, 0, 3, 0);
        check("R6 one", x_flt, 32'h3F800000);
        check("R6 half", y_flt, 32'h3F000000);
        check("R6 lsb", z_flt, 32'h34000000);
        run_one("R6 truncation", 32'hFFFFFF, 32'h0ABCDE, 32'h7FFFFF, 2, 0, 0);
    endtask

    task automatic t_zero;
        run_one("R7 zero other", 0, 0, 0, 0, 3, 0);
        check("R7 plus zero", x_flt, 32'h0);
        run_one("R7 zero negated", 0, 0, 32'h10, 3, 0, 0);
        check("R7 negated zero", y_flt, 32'h0);
    endtask

    task automatic t_negative;
        run_one("R8 negative", -32'h800000, -32'h000003, -32'hC00000, 0, 3, 0);
        check("R8 minus one", x_flt, 32'hBF800000);
        check("R8 minus 1.5", z_flt, 32'hBFC00000);
    endtask

    task automatic t_muldiv;
        run_one("R9 multiply", 32'h400000, 32'h800000, 32'h300000, 0, 1, 130);
        check("R9 mul Y", y_flt, 32'h41000000);
        check("R9 mul X positional", x_flt, 32'h3F000000);
        run_one("R9 divide", 32'h800000, 32'h200000, 32'hC00000, 0, 2, 120);
        check("R9 div Z", z_flt, 32'h3C400000);
        check("R9 div Y positional", y_flt, 32'h3E800000);
    endtask

    task automatic t_stream;
        logic [31:0] ex[4], ey[4], ez[4];
        int xs[4] = '{32'h100000, -32'h200000, 32'h7FFFFF, 32'h000101};
        int rs[4] = '{1, 4, 2, 0};
        for (int i = 0; i < 4; i++)
            expect_of(xs[i], xs[3-i], xs[i] >>> 1, rs[i], 0, 0, ex[i], ey[i], ez[i]);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 2 && i < 6) begin
                check("R10 stream valid", {31'b0, out_valid}, 32'd1);
                check("R10 stream X", x_flt, ex[i-2]);
                check("R10 stream Y", y_flt, ey[i-2]);
                check("R10 stream Z", z_flt, ez[i-2]);
            end
            if (i == 6) check("R10 stream idle", {31'b0, out_valid}, 32'd0);
            if (i < 4) drive(xs[i], xs[3-i], xs[i] >>> 1, rs[i], 0, 0, 1'b1);
            else       drive(0, 0, 0, 0, 0, 0, 1'b0);
        end
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_nontrig;
        t_region0;
        t_region1;
        t_region23;
        t_region4;
        t_format;
        t_zero;
        t_negative;
        t_muldiv;
        t_stream;
        repeat (2) @(negedge clk);
        report;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        report;
    end

endmodule